// File: doc/BRIEF.md
# Rate-Weighted Earliest-Deadline Slot Scheduler

This block decides, once per time slot, which of N flows of fixed-size cells may use a shared output link. Each flow is configured with an integer weight `w` and a start slot `s`; its share of the link is `w / F`, where `F` is the frame constant. The weights of all flows must add up to no more than `F`. A flow's k-th service (k counted from 1) may not be given before slot `s + (k-1)*F/w` (rounded down) and is due by `s + k*F/w`; the block hands each slot to the eligible flow whose due time, rounded up, is nearest. The result is a spread of services to each flow that stays within one cell of its ideal share over any stretch of slots since its start.

A slot is advanced by a one-cycle `slot_tick` pulse. The decision for that slot appears on `grant_valid` and `grant_flow` in the next clock cycle and lasts one cycle. A grant is a service opportunity only: whether the chosen flow has a cell to send is not known to the block and plays no part in the choice. The slot counter and each flow's service count are cleared by reset; configuration is expected to be held steady outside reset.

Top module: `edf_cell_mux`

## Requirements
- R1: While reset is asserted and until the first slot tick after it, `grant_valid` is 0; after reset the slot count is 0 and every flow is at its first service.
- R2: `grant_valid` is 1 only in the clock cycle right after a cycle in which `slot_tick` was 1; each tick advances the slot count by exactly one and yields at most one grant.
- R3: Flow i (weight in `cfg_weight[i*WW +: WW]`, start in `cfg_start[i*TW +: TW]`) is eligible in slot t exactly when its weight is nonzero, t >= s, and floor(s + (k-1)*F/w) <= t for its next service k.
- R4: Among eligible flows, the slot is granted to the one with the smallest ceil(s + k*F/w); `grant_flow` carries that flow's index.
- R5: When several eligible flows share the smallest rounded due slot, the lowest index wins.
- R6: A slot with no eligible flow produces no grant; a slot with at least one eligible flow always produces a grant.
- R7: A flow with weight 0 is never granted, and no flow is granted in a slot before its start slot.
- R8: The k-th grant to a flow falls in a slot t with floor(s + (k-1)*F/w) <= t < ceil(s + k*F/w).
- R9: When the weights sum to at most F, for a flow with start s the number of grants in slots s .. s+L-1 lies between floor(L*w/F) and ceil(L*w/F).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | One-cycle pulse that closes the current slot |
| cfg_weight | input | N*WW | Weight of each flow, flow i at bits i*WW +: WW |
| cfg_start | input | N*TW | Start slot of each flow, flow i at bits i*TW +: TW |
| grant_valid | output | 1 | The slot just closed was given to a flow |
| grant_flow | output | IW | Index of the granted flow |

## Verification
The per-flow state is a single service count, so a wrong count shifts that flow's eligible and due slots and shows as a grant to the wrong flow, or an idle slot where a grant was due, usually within a few slots of the fault and at the latest within one period F/w of the affected flow. Comparing every slot's grant against a model built from the eligibility and deadline rules therefore exposes it at once, and the cumulative-count bounds catch slow drifts that a single slot could hide. Tie order and the idle pattern of a lone low-rate flow are checked against fixed sequences.

// File: rtl/edf_cell_mux.sv
module edf_cell_mux #(
  parameter int N  = 4,
  parameter int WW = 5,
  parameter int F  = 16,
  parameter int TW = 12,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int EW = TW + $clog2(F + 1) + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slot_tick,
  input  logic [N*WW-1:0] cfg_weight,
  input  logic [N*TW-1:0] cfg_start,
  output logic            grant_valid,
  output logic [IW-1:0]   grant_flow
);

  logic [TW-1:0] now;
  logic [EW-1:0] used [N];
  logic [EW-1:0] due  [N];
  logic [WW-1:0] wt   [N];
  logic [N-1:0]  elig;

  for (genvar i = 0; i < N; i++) begin : g_flow
    logic [TW-1:0] st;
    logic [EW-1:0] wd, first;
    assign wt[i]   = cfg_weight[i*WW +: WW];
    assign st      = cfg_start[i*TW +: TW];
    assign wd      = (wt[i] == '0) ? EW'(1) : EW'(wt[i]);
    assign first   = EW'(st) + used[i] / wd;
    assign due[i]  = EW'(st) + (used[i] + EW'(F) + wd - EW'(1)) / wd;
    assign elig[i] = (wt[i] != '0) && (now >= st) && (first <= EW'(now));
  end

  logic          pick_ok;
  logic [IW-1:0] pick;
  logic [EW-1:0] pick_due;

  always_comb begin
    pick_ok  = 1'b0;
    pick     = '0;
    pick_due = '0;
    for (int i = 0; i < N; i++)
      if (elig[i] && (!pick_ok || due[i] < pick_due)) begin
        pick_ok  = 1'b1;
        pick     = IW'(i);
        pick_due = due[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now         <= '0;
      grant_valid <= 1'b0;
      grant_flow  <= '0;
      for (int i = 0; i < N; i++) used[i] <= '0;
    end else begin
      grant_valid <= slot_tick && pick_ok;
      if (slot_tick) begin
        now <= now + TW'(1);
        if (pick_ok) begin
          grant_flow  <= pick;
          used[pick]  <= used[pick] + EW'(F);
        end
      end
    end
  end

  AST_NO_TICK_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> !grant_valid); // R2
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |=> now == $past(now) + TW'(1)); // R2
  AST_ZERO_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> wt[grant_flow] != '0); // R7
  AST_BEFORE_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && pick_ok) |-> EW'(now) < pick_due); // R8
  AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && elig == '0) |=> !grant_valid); // R6
  AST_BUSY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && elig != '0) |=> grant_valid); // R6

endmodule

// File: tb/sim_edf_cell_mux.sv
module sim_edf_cell_mux;
  localparam int PER = 10;
  localparam int N = 4, WW = 5, F = 16, TW = 12;

  logic clk = 0, rst_n = 0, slot_tick = 0;
  logic [N*WW-1:0] cfg_weight = '0;
  logic [N*TW-1:0] cfg_start = '0;
  logic grant_valid;
  logic [1:0] grant_flow;

  edf_cell_mux #(.N(N), .WW(WW), .F(F), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick),
    .cfg_weight(cfg_weight), .cfg_start(cfg_start),
    .grant_valid(grant_valid), .grant_flow(grant_flow));

  always #(PER/2) clk = ~clk;

  int tests = 0, fails = 0, t = 0;
  bit done = 0;
  longint me [N];
  int cnt [N], wv [N], sv [N];
  int gv [512], gi [512];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setup(int w0, int w1, int w2, int w3, int s0, int s1, int s2, int s3);
    @(negedge clk);
    rst_n = 0; slot_tick = 0;
    wv[0] = w0; wv[1] = w1; wv[2] = w2; wv[3] = w3;
    sv[0] = s0; sv[1] = s1; sv[2] = s2; sv[3] = s3;
    for (int i = 0; i < N; i++) begin
      cfg_weight[i*WW +: WW] = WW'(wv[i]);
      cfg_start[i*TW +: TW]  = TW'(sv[i]);
      me[i] = 0; cnt[i] = 0;
    end
    t = 0;
    repeat (3) @(negedge clk);
    chk(grant_valid == 0, "R1", "grant during reset", grant_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(grant_valid == 0, "R1", "grant before first tick", grant_valid, 0);
  endtask

  task automatic slot(bit gap);
    bit found = 0;
    int best = 0;
    longint bd = 0;
    for (int i = 0; i < N; i++) begin
      longint d;
      bit el;
      el = (wv[i] != 0) && (t >= sv[i]) && (me[i] < longint'(t - sv[i] + 1) * wv[i]);
      d = (wv[i] != 0) ? sv[i] + (me[i] + F + wv[i] - 1) / wv[i] : 0;
      if (el && (!found || d < bd)) begin found = 1; best = i; bd = d; end
    end
    slot_tick = 1;
    @(negedge clk);
    slot_tick = 0;
    chk(grant_valid == found, "R3", $sformatf("valid slot %0d", t), grant_valid, found);
    if (found && grant_valid)
      chk(grant_flow == best, "R4", $sformatf("flow slot %0d", t), grant_flow, best);
    if (grant_valid) begin
      int g = grant_flow;
      longint lo = sv[g] + ((wv[g] != 0) ? me[g] / wv[g] : 0);
      longint hi = (wv[g] != 0) ? sv[g] + (me[g] + F + wv[g] - 1) / wv[g] : 0;
      chk(t >= lo && t < hi, "R8", $sformatf("window flow %0d slot %0d", g, t), t, lo);
    end
    gv[t] = grant_valid;
    gi[t] = grant_flow;
    if (found) begin me[best] += F; cnt[best]++; end
    t++;
    if (gap) begin
      @(negedge clk);
      chk(grant_valid == 0, "R2", "grant without tick", grant_valid, 0);
    end
  endtask

  task automatic cum_check();
    for (int i = 0; i < N; i++)
      if (wv[i] != 0 && sv[i] < t) begin
        longint l = t - sv[i];
        longint lo = l * wv[i] / F;
        longint hi = (l * wv[i] + F - 1) / F;
        chk(cnt[i] >= lo && cnt[i] <= hi, "R9", $sformatf("count flow %0d", i), cnt[i], lo);
      end
  endtask

  task automatic t_pair();
    setup(10, 4, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 64; k++) slot(0);
    cum_check();
  endtask

  task automatic t_full();
    setup(5, 7, 4, 0, 0, 0, 0, 0);
    for (int k = 0; k < 80; k++) slot(0);
    for (int k = 0; k < 80; k++)
      chk(gv[k] == 1, "R6", $sformatf("idle at full load slot %0d", k), gv[k], 1);
    cum_check();
  endtask

  task automatic t_zero_start();
    setup(0, 6, 3, 0, 0, 0, 20, 0);
    for (int k = 0; k < 60; k++) slot(k[0]);
    chk(cnt[0] == 0, "R7", "zero weight flow 0 granted", cnt[0], 0);
    chk(cnt[3] == 0, "R7", "zero weight flow 3 granted", cnt[3], 0);
    for (int k = 0; k < 20; k++)
      if (gv[k]) chk(gi[k] != 2, "R7", $sformatf("flow 2 before start slot %0d", k), gi[k], 1);
    cum_check();
  endtask

  task automatic t_tie();
    setup(4, 4, 4, 4, 0, 0, 0, 0);
    for (int k = 0; k < 16; k++) slot(0);
    for (int k = 0; k < 16; k++)
      chk(gv[k] == 1 && gi[k] == k % 4, "R5", $sformatf("tie order slot %0d", k), gi[k], k % 4);
  endtask

  task automatic t_idle();
    setup(2, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 40; k++) slot(0);
    for (int k = 0; k < 40; k++)
      chk(gv[k] == (k % 8 == 0), "R6", $sformatf("lone flow slot %0d", k), gv[k], k % 8 == 0);
    cum_check();
  endtask

  initial begin
    #(PER * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_pair();
    t_full();
    t_zero_start();
    t_tie();
    t_idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule